// File: doc/BRIEF.md
# Dual Byte Buffer with Level-Threshold Interrupts

This block holds two independent byte queues between a host and a modem-side engine. The host loads transmit bytes into one queue and the modem side drains them. The modem side loads received bytes into the other queue and the host drains them. Each queue is 64 entries deep. A small configuration port sets three 6-bit level thresholds and a mask of interrupt enables.

Seven sticky event flags record events: threshold crossings, writes dropped on a full queue, and reads from an empty queue. The flags latch whatever the mask holds. The mask only decides which pending flags pull the shared active-low interrupt line. A host strobe clears the flags it has just seen. Each queue has its own clear input that empties it at once.

Top module: `fifo_irq_pair`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. Each holds up to 2^AW (default 64) bytes. The head byte appears combinationally on the read-data output while the queue is not empty.
- R2: A write to a full queue is discarded. It sets status bit 3 (transmit queue, host side) or status bit 5 (receive queue, modem side).
- R3: A read from an empty queue leaves the queue unchanged, and its read-data output is 0x00. It sets status bit 4 (transmit queue, modem side) or status bit 6 (receive queue, host side).
- R4: Status bit 0 (transmit) or bit 2 (receive) sets at the clock edge where that queue's level moves from at or below its almost-full threshold to above it.
- R5: Status bit 1 sets at the clock edge where the transmit level moves from above the almost-empty threshold to at or below it.
- R6: The configuration address selects one register: 0 is the transmit almost-full threshold (reset 0x37), 1 is the transmit almost-empty threshold (reset 0x04), 2 is the receive almost-full threshold (reset 0x37), and 3 is the enable mask (reset 0x00, bit n enables status bit n). The read data shows the selected register combinationally.
- R7: Bits 7:6 of the three threshold registers and bit 7 of the enable mask read as zero, and writes to them are ignored. Status bit 7 is always zero.
- R8: tx_clr empties only the transmit queue, and rx_clr empties only the receive queue. A clear takes priority over a push or pop on the same queue in the same cycle. A clear counts as a level change for the crossing rules.
- R9: Status bits stay set until stat_rd is high at a clock edge. That edge clears them, but any event occurring at the same edge leaves its bit set.
- R10: irq_n is low exactly when at least one status bit and its enable bit are both set. A masked bit still sets and reads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_clr | input | 1 | Empty the receive queue |
| host_tx_wr | input | 1 | Host pushes a transmit byte |
| host_tx_data | input | 8 | Byte pushed by host |
| mdm_tx_rd | input | 1 | Modem pops a transmit byte |
| mdm_tx_data | output | 8 | Transmit head byte, 0 when empty |
| mdm_rx_wr | input | 1 | Modem pushes a received byte |
| mdm_rx_data | input | 8 | Byte pushed by modem |
| host_rx_rd | input | 1 | Host pops a received byte |
| host_rx_data | output | 8 | Receive head byte, 0 when empty |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register |
| stat_rd | input | 1 | Read-to-clear strobe for status |
| status | output | 8 | Sticky event flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit data, 64-entry queues, and thresholds reset to 55 and 4. With these values, the bench can fill each queue past its almost-full threshold and then overflow it, and can drain the transmit queue through its almost-empty threshold and then underflow it, all within a few hundred cycles. The bench runs each threshold exactly on the boundary byte. It also exercises a status clear that coincides with a new overflow, and a queue clear that coincides with a push.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    localparam int THR_W  = 6;
    localparam int NUM_ST = 7;

    // status bit positions
    localparam int ST_TX_AF  = 0;
    localparam int ST_TX_AE  = 1;
    localparam int ST_RX_AF  = 2;
    localparam int ST_TX_OVF = 3;
    localparam int ST_TX_UDF = 4;
    localparam int ST_RX_OVF = 5;
    localparam int ST_RX_UDF = 6;

    // configuration addresses
    localparam logic [1:0] A_TX_AF = 2'd0;
    localparam logic [1:0] A_TX_AE = 2'd1;
    localparam logic [1:0] A_RX_AF = 2'd2;
    localparam logic [1:0] A_EN    = 2'd3;

    typedef struct packed {
        logic [THR_W-1:0]  tx_af;
        logic [THR_W-1:0]  tx_ae;
        logic [THR_W-1:0]  rx_af;
        logic [NUM_ST-1:0] en;
        logic [NUM_ST-1:0] stat;
    } ctrl_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int W  = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [AW:0]   level,
    output logic [AW:0]   level_next,
    output logic          overflow,
    output logic          underflow
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic full, empty, do_wr, do_rd;

    assign full  = (s_q.cnt == (AW+1)'(DEPTH));
    assign empty = (s_q.cnt == '0);

    always_comb begin
        s_d       = s_q;
        do_wr     = wr && !clr && !full;
        do_rd     = rd && !clr && !empty;
        overflow  = wr && !clr && full;
        underflow = rd && !clr && empty;
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_wr) s_d.wp = s_q.wp + 1'b1;
            if (do_rd) s_d.rp = s_q.rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[s_q.wp] <= wdata;
    end

    assign rdata      = empty ? '0 : mem[s_q.rp];
    assign level      = s_q.cnt;
    assign level_next = s_d.cnt;
endmodule

// File: rtl/level_cross.sv
module level_cross #(
    parameter int LW     = 7,
    parameter int THR_W  = 6,
    parameter bit RISING = 1'b1
) (
    input  logic [LW-1:0]    lvl_now,
    input  logic [LW-1:0]    lvl_next,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);
    logic [LW-1:0] thr_x;
    assign thr_x = LW'(thr);

    generate
        if (RISING) begin : g_up
            assign hit = (lvl_now <= thr_x) && (lvl_next > thr_x);
        end else begin : g_down
            assign hit = (lvl_now > thr_x) && (lvl_next <= thr_x);
        end
    endgenerate
endmodule

// File: rtl/fifo_irq_pair.sv
module fifo_irq_pair
    import fifo_irq_pkg::*;
#(
    parameter int W         = 8,
    parameter int AW        = 6,
    parameter int TX_AF_RST = 55,
    parameter int TX_AE_RST = 4,
    parameter int RX_AF_RST = 55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_clr,
    input  logic         rx_clr,
    input  logic         host_tx_wr,
    input  logic [W-1:0] host_tx_data,
    input  logic         mdm_tx_rd,
    output logic [W-1:0] mdm_tx_data,
    input  logic         mdm_rx_wr,
    input  logic [W-1:0] mdm_rx_data,
    input  logic         host_rx_rd,
    output logic [W-1:0] host_rx_data,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_addr,
    input  logic [7:0]   cfg_wdata,
    output logic [7:0]   cfg_rdata,
    input  logic         stat_rd,
    output logic [7:0]   status,
    output logic         irq_n
);
    localparam int LW = AW + 1;

    logic [LW-1:0] tx_lvl, tx_lvl_nx, rx_lvl, rx_lvl_nx;
    logic tx_ovf, tx_udf, rx_ovf, rx_udf;
    logic tx_af_hit, tx_ae_hit, rx_af_hit;
    logic [NUM_ST-1:0] set_ev;
    ctrl_t r_d, r_q;

    byte_fifo #(.W(W), .AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .wr(host_tx_wr), .wdata(host_tx_data),
        .rd(mdm_tx_rd), .rdata(mdm_tx_data),
        .level(tx_lvl), .level_next(tx_lvl_nx),
        .overflow(tx_ovf), .underflow(tx_udf)
    );

    byte_fifo #(.W(W), .AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .wr(mdm_rx_wr), .wdata(mdm_rx_data),
        .rd(host_rx_rd), .rdata(host_rx_data),
        .level(rx_lvl), .level_next(rx_lvl_nx),
        .overflow(rx_ovf), .underflow(rx_udf)
    );

    level_cross #(.LW(LW), .THR_W(THR_W), .RISING(1'b1)) u_tx_af (
        .lvl_now(tx_lvl), .lvl_next(tx_lvl_nx), .thr(r_q.tx_af), .hit(tx_af_hit)
    );
    level_cross #(.LW(LW), .THR_W(THR_W), .RISING(1'b0)) u_tx_ae (
        .lvl_now(tx_lvl), .lvl_next(tx_lvl_nx), .thr(r_q.tx_ae), .hit(tx_ae_hit)
    );
    level_cross #(.LW(LW), .THR_W(THR_W), .RISING(1'b1)) u_rx_af (
        .lvl_now(rx_lvl), .lvl_next(rx_lvl_nx), .thr(r_q.rx_af), .hit(rx_af_hit)
    );

    always_comb begin
        r_d    = r_q;
        set_ev = '0;
        set_ev[ST_TX_AF]  = tx_af_hit;
        set_ev[ST_TX_AE]  = tx_ae_hit;
        set_ev[ST_RX_AF]  = rx_af_hit;
        set_ev[ST_TX_OVF] = tx_ovf;
        set_ev[ST_TX_UDF] = tx_udf;
        set_ev[ST_RX_OVF] = rx_ovf;
        set_ev[ST_RX_UDF] = rx_udf;
        if (cfg_we) begin
            case (cfg_addr)
                A_TX_AF: r_d.tx_af = cfg_wdata[THR_W-1:0];
                A_TX_AE: r_d.tx_ae = cfg_wdata[THR_W-1:0];
                A_RX_AF: r_d.rx_af = cfg_wdata[THR_W-1:0];
                default: r_d.en    = cfg_wdata[NUM_ST-1:0];
            endcase
        end
        r_d.stat = (stat_rd ? '0 : r_q.stat) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tx_af <= THR_W'(TX_AF_RST);
            r_q.tx_ae <= THR_W'(TX_AE_RST);
            r_q.rx_af <= THR_W'(RX_AF_RST);
            r_q.en    <= '0;
            r_q.stat  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (cfg_addr)
            A_TX_AF: cfg_rdata = 8'(r_q.tx_af);
            A_TX_AE: cfg_rdata = 8'(r_q.tx_ae);
            A_RX_AF: cfg_rdata = 8'(r_q.rx_af);
            default: cfg_rdata = 8'(r_q.en);
        endcase
    end

    assign status = 8'(r_q.stat);
    assign irq_n  = ~|(r_q.stat & r_q.en);
endmodule

// File: rtl/fifo_irq_pair_chk.sv
module fifo_irq_pair_chk #(
    parameter int W  = 8,
    parameter int AW = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_clr,
    input logic         rx_clr,
    input logic         host_tx_wr,
    input logic         mdm_tx_rd,
    input logic [W-1:0] mdm_tx_data,
    input logic         mdm_rx_wr,
    input logic         host_rx_rd,
    input logic [1:0]   cfg_addr,
    input logic [7:0]   cfg_rdata,
    input logic         stat_rd,
    input logic [7:0]   status,
    input logic         irq_n,
    input logic [AW:0]  tx_lvl,
    input logic [AW:0]  rx_lvl
);
    localparam int DEPTH = 1 << AW;

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= (AW+1)'(DEPTH)) && (rx_lvl <= (AW+1)'(DEPTH)));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_wr && !tx_clr && !mdm_tx_rd && tx_lvl == (AW+1)'(DEPTH))
        |=> (status[3] && tx_lvl == (AW+1)'(DEPTH)));

    assert_empty_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdm_tx_rd && tx_lvl == '0) |-> (mdm_tx_data == '0));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != 2'd3) |-> (cfg_rdata[7:6] == 2'b00));

    assert_clear_own_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !rx_clr && !mdm_rx_wr && !host_rx_rd) |=> (tx_lvl == '0 && $stable(rx_lvl)));

    assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (status != 8'h00));
endmodule

bind fifo_irq_pair fifo_irq_pair_chk #(.W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .host_tx_wr(host_tx_wr), .mdm_tx_rd(mdm_tx_rd), .mdm_tx_data(mdm_tx_data),
    .mdm_rx_wr(mdm_rx_wr), .host_rx_rd(host_rx_rd),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .stat_rd(stat_rd), .status(status), .irq_n(irq_n),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/fifo_irq_pair_test.sv
module fifo_irq_pair_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_clr = 0, rx_clr = 0;
    logic host_tx_wr = 0, mdm_tx_rd = 0, mdm_rx_wr = 0, host_rx_rd = 0;
    logic [7:0] host_tx_data = 0, mdm_rx_data = 0;
    logic [7:0] mdm_tx_data, host_rx_data;
    logic cfg_we = 0;
    logic [1:0] cfg_addr = 0;
    logic [7:0] cfg_wdata = 0, cfg_rdata;
    logic stat_rd = 0;
    logic [7:0] status;
    logic irq_n;

    int n_chk = 0, n_fail = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #5 clk = ~clk;

    fifo_irq_pair uut (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitors: compare popped bytes with the scoreboard queues
    always @(negedge clk) begin
        #2;
        if (mdm_tx_rd) begin
            if (tx_q.size() > 0) check("R1", "tx byte order", mdm_tx_data, tx_q.pop_front());
            else                 check("R3", "tx empty read data", mdm_tx_data, 0);
        end
        if (host_rx_rd) begin
            if (rx_q.size() > 0) check("R1", "rx byte order", host_rx_data, rx_q.pop_front());
            else                 check("R3", "rx empty read data", host_rx_data, 0);
        end
    end

    // drivers
    task automatic tx_push(input logic [7:0] b, input bit with_srd = 0);
        @(negedge clk);
        host_tx_wr = 1; host_tx_data = b; stat_rd = with_srd;
        if (tx_q.size() < 64) tx_q.push_back(b);
        @(negedge clk);
        host_tx_wr = 0; stat_rd = 0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        mdm_rx_wr = 1; mdm_rx_data = b;
        if (rx_q.size() < 64) rx_q.push_back(b);
        @(negedge clk);
        mdm_rx_wr = 0;
    endtask

    task automatic tx_pop();
        @(negedge clk); mdm_tx_rd = 1;
        @(negedge clk); mdm_tx_rd = 0;
    endtask

    task automatic rx_pop();
        @(negedge clk); host_rx_rd = 1;
        @(negedge clk); host_rx_rd = 0;
    endtask

    task automatic clear_status();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic cfg_check(input logic [1:0] a, input int exp, input string req);
        @(negedge clk); cfg_addr = a; #1;
        check(req, "cfg readback", cfg_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        @(negedge clk);
        check("R9", "reset status", status, 8'h00);
        check("R10", "reset irq_n", irq_n, 1);
        check("R3", "reset tx head", mdm_tx_data, 0);
        cfg_check(2'd0, 8'h37, "R6");
        cfg_check(2'd1, 8'h04, "R6");
        cfg_check(2'd2, 8'h37, "R6");
        cfg_check(2'd3, 8'h00, "R6");
        // reserved bits
        cfg_write(2'd0, 8'hFF);
        cfg_check(2'd0, 8'h3F, "R7");
        cfg_write(2'd3, 8'hFF);
        cfg_check(2'd3, 8'h7F, "R7");
        check("R7", "status bit7", status[7], 0);
        cfg_write(2'd0, 8'hC0 | 8'h37);
        cfg_check(2'd0, 8'h37, "R7");
        cfg_write(2'd3, 8'h00);

        // TX almost-full crossing at 55 -> 56
        for (int i = 0; i < 55; i++) tx_push(8'(i + 1));
        check("R4", "tx af below threshold", status, 8'h00);
        tx_push(8'd56);
        check("R4", "tx af set", status, 8'h01);
        check("R10", "masked flag keeps irq high", irq_n, 1);
        cfg_write(2'd3, 8'h01);
        check("R10", "enabled flag pulls irq low", irq_n, 0);
        clear_status();
        check("R9", "status cleared", status, 8'h00);
        check("R10", "irq released", irq_n, 1);

        // fill to 64, then overflow
        for (int i = 56; i < 64; i++) tx_push(8'(i + 1));
        check("R4", "no re-trigger above threshold", status, 8'h00);
        tx_push(8'hEE);
        check("R2", "tx overflow flag", status, 8'h08);
        check("R10", "overflow masked", irq_n, 1);
        tx_push(8'hEF, 1'b1);
        check("R9", "same-edge event survives clear", status, 8'h08);
        clear_status();

        // drain through almost-empty threshold 5 -> 4
        for (int i = 0; i < 59; i++) tx_pop();
        check("R5", "tx ae not yet", status, 8'h00);
        tx_pop();
        check("R5", "tx ae set", status, 8'h02);
        for (int i = 0; i < 4; i++) tx_pop();
        tx_pop();
        check("R3", "tx underflow flag", status, 8'h12);
        clear_status();

        // clears act per queue
        for (int i = 0; i < 20; i++) rx_push(8'hA0 + 8'(i));
        for (int i = 0; i < 3; i++) tx_push(8'h50 + 8'(i));
        @(negedge clk); tx_clr = 1;
        @(negedge clk); tx_clr = 0;
        tx_q.delete();
        check("R8", "tx clear no flag", status, 8'h00);
        tx_pop();
        check("R8", "tx emptied by clear", status, 8'h10);
        for (int i = 0; i < 20; i++) rx_pop();
        check("R8", "rx untouched by tx clear", status, 8'h10);
        clear_status();
        // clear wins over push
        @(negedge clk); tx_clr = 1; host_tx_wr = 1; host_tx_data = 8'h77;
        @(negedge clk); tx_clr = 0; host_tx_wr = 0;
        tx_pop();
        check("R8", "clear beats push", status, 8'h10);
        clear_status();

        // RX almost-full and overflow
        for (int i = 0; i < 55; i++) rx_push(8'(i * 3));
        check("R4", "rx af below threshold", status, 8'h00);
        rx_push(8'h99);
        check("R4", "rx af set", status, 8'h04);
        for (int i = 56; i < 64; i++) rx_push(8'(i));
        rx_push(8'h44);
        check("R2", "rx overflow flag", status, 8'h24);
        @(negedge clk); rx_clr = 1;
        @(negedge clk); rx_clr = 0;
        rx_q.delete();
        rx_pop();
        check("R3", "rx underflow flag", status, 8'h64);
        check("R10", "irq high, only bit0 enabled", irq_n, 1);
        cfg_write(2'd3, 8'h04);
        check("R10", "irq low on rx af enable", irq_n, 0);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule